// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Sample Handoff Buffer

This block passes fixed-length sample symbols from a receiver running on one clock to a processor running on another. The storage is a two-port RAM split into two banks. The receiver fills one bank while the processor reads the other. When a fill finishes, the bank is handed to the processor, which gets a one-cycle interrupt pulse and a level that says a bank is held. Every change of ownership crosses the clock boundary as a per-bank toggle through a two-flop synchronizer. Because of this, the receiver never writes into a bank the processor still holds.

The processor reads with a word offset only. The bank-select bit of the RAM read address comes from the bank the processor currently holds, so the same offsets serve both banks. When the processor is done with a bank it pulses a release. If a new symbol starts while the next bank in turn is still held, the whole symbol is dropped and a sticky overrun flag is raised, which the processor can clear. A small set of 32-bit parameter words, written from the processor side, is also kept beside the buffer.

Top module: `pp_handoff_buf`

## Requirements
- R1: After reset, rd_valid, rd_irq and rd_overrun are 0 and every parameter word reads 0.
- R2: A symbol begins with a word that has wr_valid and wr_sof both high. That word and the next BANK_WORDS-1 words with wr_valid high (and wr_sof low) are stored at offsets 0 to BANK_WORDS-1. After the last word, the bank passes to the reader: rd_irq pulses for exactly one rclk cycle and rd_valid is 1 in that cycle.
- R3: Banks are filled in strict alternation starting with bank 0. rd_bank shows the held bank, and banks reach the reader in the order they were filled.
- R4: When rd_en is high at an rclk edge, the word at offset rd_addr of the bank shown by rd_bank appears on rd_data after that edge.
- R5: rd_release while rd_valid is 1 returns the held bank to the writer and moves rd_bank to the other bank. rd_release while rd_valid is 0 has no effect.
- R6: The writer never writes a bank the reader holds. A symbol start that finds the next bank held drops the whole symbol: stored data is unchanged and no rd_irq follows.
- R7: A dropped symbol sets a sticky overrun flag, seen on rd_overrun after synchronization. A rd_ovr_clr pulse clears it.
- R8: A wr_sof during a fill restarts that fill at offset 0 in the same bank.
- R9: Words with wr_valid high and wr_sof low are ignored while no fill is in progress.
- R10: prm_we writes prm_wdata into parameter word prm_addr at an rclk edge. Word i is shown on prm_words bits [32i+31:32i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Receiver (write) clock |
| wrst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_valid | input | 1 | Sample word present |
| wr_sof | input | 1 | Marks the first word of a symbol |
| wr_data | input | DATA_W | Sample word |
| rclk | input | 1 | Processor (read) clock |
| rrst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | BANK_AW | Word offset inside the held bank |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | A filled bank is held by the reader |
| rd_bank | output | 1 | Index of the bank presented to the reader |
| rd_irq | output | 1 | One-cycle pulse when a bank arrives |
| rd_release | input | 1 | Return the held bank to the writer |
| rd_overrun | output | 1 | Sticky symbol-drop flag, synchronized |
| rd_ovr_clr | input | 1 | Clear the overrun flag |
| prm_we | input | 1 | Parameter word write strobe |
| prm_addr | input | PRM_AW | Parameter word index |
| prm_wdata | input | DATA_W | Parameter write data |
| prm_words | output | PRM_N*DATA_W | All parameter words, word i at bits [32i+31:32i] |

## Verification
The assertions watch, on every cycle, that no write lands in a reader-held bank, that a drop sets the overrun flag and the flag stays set until a clear arrives, that each interrupt is a single cycle that comes with rd_valid, and that rd_bank moves exactly on an accepted release. Some behaviours need the whole handoff across both clocks and can only be shown by the bench's scenarios: stored data matches what was written, banks alternate, a dropped symbol leaves the held data intact, a restart discards the partial symbol, and stray words or releases are ignored.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef logic bank_t;

  localparam int unsigned NUM_BANKS = 2;

  function automatic bank_t other_bank(input bank_t b);
    return ~b;
  endfunction

  function automatic logic [NUM_BANKS-1:0] toggle_events(
      input logic [NUM_BANKS-1:0] synced,
      input logic [NUM_BANKS-1:0] seen);
    return synced ^ seen;
  endfunction

  function automatic logic [NUM_BANKS-1:0] bank_onehot(input bank_t b);
    return b ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/pp_sync2.sv
module pp_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/pp_dc_ram.sv
module pp_dc_ram #(
  parameter int AW = 10,
  parameter int W  = 32
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl
  import pp_pkg::*;
#(
  parameter int BANK_AW = 9,
  parameter int DATA_W  = 32
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_valid,
  input  logic              wr_sof,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rel_sync,
  input  logic              clr_sync,
  output logic              mem_we,
  output logic [BANK_AW:0]  mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [1:0]        ready_tgl,
  output logic              ovr_flag,
  output logic [1:0]        held,
  output logic              fill_done,
  output logic              drop_evt,
  output logic              clr_evt
);
  localparam logic [BANK_AW-1:0] LAST_OFF = {BANK_AW{1'b1}};

  logic [1:0]         held_q, rel_seen_q, ready_tgl_q, rel_evt;
  bank_t              bank_q;
  logic               filling_q, ovr_q, clr_seen_q, start_ok;
  logic [BANK_AW-1:0] addr_q, off;

  always_comb begin
    start_ok  = wr_valid & wr_sof & ~held_q[bank_q];
    drop_evt  = wr_valid & wr_sof & held_q[bank_q];
    mem_we    = start_ok | (wr_valid & ~wr_sof & filling_q);
    off       = wr_sof ? '0 : addr_q;
    fill_done = mem_we & (off == LAST_OFF);
    rel_evt   = toggle_events(rel_sync, rel_seen_q);
    clr_evt   = clr_sync ^ clr_seen_q;
  end

  assign mem_waddr = {bank_q, off};
  assign mem_wdata = wr_data;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      held_q      <= '0;
      rel_seen_q  <= '0;
      ready_tgl_q <= '0;
      bank_q      <= 1'b0;
      filling_q   <= 1'b0;
      ovr_q       <= 1'b0;
      clr_seen_q  <= 1'b0;
      addr_q      <= '0;
    end else begin
      rel_seen_q <= rel_sync;
      clr_seen_q <= clr_sync;
      held_q     <= (held_q & ~rel_evt) | (fill_done ? bank_onehot(bank_q) : 2'b00);
      if (drop_evt)     ovr_q <= 1'b1;
      else if (clr_evt) ovr_q <= 1'b0;
      if (fill_done) begin
        filling_q   <= 1'b0;
        addr_q      <= '0;
        bank_q      <= other_bank(bank_q);
        ready_tgl_q <= ready_tgl_q ^ bank_onehot(bank_q);
      end else if (mem_we) begin
        filling_q <= 1'b1;
        addr_q    <= off + 1'b1;
      end else if (drop_evt) begin
        filling_q <= 1'b0;
        addr_q    <= '0;
      end
    end
  end

  assign ready_tgl = ready_tgl_q;
  assign ovr_flag  = ovr_q;
  assign held      = held_q;
endmodule

// File: rtl/pp_rd_ctrl.sv
module pp_rd_ctrl
  import pp_pkg::*;
(
  input  logic       rclk,
  input  logic       rrst_n,
  input  logic [1:0] ready_sync,
  input  logic       rd_release,
  input  logic       rd_ovr_clr,
  output logic [1:0] rel_tgl,
  output logic       clr_tgl,
  output logic       rd_irq,
  output logic       rd_valid,
  output logic       rd_bank,
  output logic       release_evt
);
  logic [1:0] full_q, ready_seen_q, rel_tgl_q, ready_evt;
  bank_t      head_q;
  logic       irq_q, clr_tgl_q;

  always_comb begin
    ready_evt   = toggle_events(ready_sync, ready_seen_q);
    release_evt = rd_release & full_q[head_q];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      full_q       <= '0;
      ready_seen_q <= '0;
      rel_tgl_q    <= '0;
      head_q       <= 1'b0;
      irq_q        <= 1'b0;
      clr_tgl_q    <= 1'b0;
    end else begin
      ready_seen_q <= ready_sync;
      irq_q        <= |ready_evt;
      full_q       <= (full_q & ~(release_evt ? bank_onehot(head_q) : 2'b00)) | ready_evt;
      if (release_evt) begin
        rel_tgl_q <= rel_tgl_q ^ bank_onehot(head_q);
        head_q    <= other_bank(head_q);
      end
      if (rd_ovr_clr) clr_tgl_q <= ~clr_tgl_q;
    end
  end

  assign rel_tgl  = rel_tgl_q;
  assign clr_tgl  = clr_tgl_q;
  assign rd_irq   = irq_q;
  assign rd_valid = full_q[head_q];
  assign rd_bank  = head_q;
endmodule

// File: rtl/pp_param_bank.sv
module pp_param_bank #(
  parameter int N  = 4,
  parameter int W  = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [N*W-1:0] words
);
  for (genvar i = 0; i < N; i++) begin : g_word
    logic [W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        word_q <= '0;
      else if (we && addr == AW'(i))     word_q <= wdata;
    end
    assign words[i*W +: W] = word_q;
  end
endmodule

// File: rtl/pp_handoff_buf.sv
module pp_handoff_buf #(
  parameter int DATA_W  = 32,
  parameter int BANK_AW = 9,
  parameter int PRM_N   = 4,
  parameter int PRM_AW  = (PRM_N > 1) ? $clog2(PRM_N) : 1
) (
  input  logic                    wclk,
  input  logic                    wrst_n,
  input  logic                    wr_valid,
  input  logic                    wr_sof,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    rclk,
  input  logic                    rrst_n,
  input  logic                    rd_en,
  input  logic [BANK_AW-1:0]      rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_valid,
  output logic                    rd_bank,
  output logic                    rd_irq,
  input  logic                    rd_release,
  output logic                    rd_overrun,
  input  logic                    rd_ovr_clr,
  input  logic                    prm_we,
  input  logic [PRM_AW-1:0]       prm_addr,
  input  logic [DATA_W-1:0]       prm_wdata,
  output logic [PRM_N*DATA_W-1:0] prm_words
);
  localparam int MEM_AW = BANK_AW + 1;

  logic              mem_we;
  logic [MEM_AW-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [1:0]        ready_tgl, ready_sync, rel_tgl, rel_sync, held_w;
  logic              clr_tgl, clr_sync, ovr_w, fill_done, drop_evt, clr_evt;
  logic              release_evt;

  pp_sync2 #(.W(2)) u_rel_sync (.clk(wclk), .rst_n(wrst_n), .d(rel_tgl), .q(rel_sync));
  pp_sync2 #(.W(1)) u_clr_sync (.clk(wclk), .rst_n(wrst_n), .d(clr_tgl), .q(clr_sync));

  pp_wr_ctrl #(.BANK_AW(BANK_AW), .DATA_W(DATA_W)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_sof(wr_sof),
    .wr_data(wr_data), .rel_sync(rel_sync), .clr_sync(clr_sync),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .ready_tgl(ready_tgl), .ovr_flag(ovr_w), .held(held_w),
    .fill_done(fill_done), .drop_evt(drop_evt), .clr_evt(clr_evt)
  );

  pp_sync2 #(.W(2)) u_rdy_sync (.clk(rclk), .rst_n(rrst_n), .d(ready_tgl), .q(ready_sync));
  pp_sync2 #(.W(1)) u_ovr_sync (.clk(rclk), .rst_n(rrst_n), .d(ovr_w), .q(rd_overrun));

  pp_rd_ctrl u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .ready_sync(ready_sync),
    .rd_release(rd_release), .rd_ovr_clr(rd_ovr_clr),
    .rel_tgl(rel_tgl), .clr_tgl(clr_tgl), .rd_irq(rd_irq),
    .rd_valid(rd_valid), .rd_bank(rd_bank), .release_evt(release_evt)
  );

  assign mem_raddr = {rd_bank, rd_addr};

  pp_dc_ram #(.AW(MEM_AW), .W(DATA_W)) u_ram (
    .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .rclk(rclk), .re(rd_en), .raddr(mem_raddr), .rdata(rd_data)
  );

  pp_param_bank #(.N(PRM_N), .W(DATA_W), .AW(PRM_AW)) u_prm (
    .clk(rclk), .rst_n(rrst_n), .we(prm_we), .addr(prm_addr),
    .wdata(prm_wdata), .words(prm_words)
  );
endmodule

// File: rtl/pp_handoff_buf_chk.sv
module pp_handoff_buf_chk #(
  parameter int BANK_AW = 9
) (
  input logic             wclk,
  input logic             wrst_n,
  input logic             rclk,
  input logic             rrst_n,
  input logic             mem_we,
  input logic [BANK_AW:0] mem_waddr,
  input logic [1:0]       held_w,
  input logic             ovr_w,
  input logic             drop_evt,
  input logic             clr_evt,
  input logic             rd_irq,
  input logic             rd_valid,
  input logic             rd_bank,
  input logic             release_evt
);
  a_r6_no_write_into_held: assert property (@(posedge wclk) disable iff (!wrst_n)
    mem_we |-> !held_w[mem_waddr[BANK_AW]]);

  a_r7_drop_sets_overrun: assert property (@(posedge wclk) disable iff (!wrst_n)
    drop_evt |=> ovr_w);

  a_r7_overrun_sticky: assert property (@(posedge wclk) disable iff (!wrst_n)
    (ovr_w && !clr_evt) |=> ovr_w);

  a_r2_irq_single_cycle: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_irq |=> !rd_irq);

  a_r2_irq_with_valid: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_irq |-> rd_valid);

  a_r5_release_advances: assert property (@(posedge rclk) disable iff (!rrst_n)
    release_evt |=> (rd_bank != $past(rd_bank)));

  a_r5_bank_holds: assert property (@(posedge rclk) disable iff (!rrst_n)
    !release_evt |=> $stable(rd_bank));
endmodule

bind pp_handoff_buf pp_handoff_buf_chk #(.BANK_AW(BANK_AW)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .held_w(held_w), .ovr_w(ovr_w),
  .drop_evt(drop_evt), .clr_evt(clr_evt), .rd_irq(rd_irq),
  .rd_valid(rd_valid), .rd_bank(rd_bank), .release_evt(release_evt)
);

// File: tb/tb_pp_handoff_buf.sv
`timescale 1ns/1ps
module tb_pp_handoff_buf;
  localparam int DATA_W  = 32;
  localparam int BANK_AW = 9;
  localparam int WORDS   = 1 << BANK_AW;
  localparam int PRM_N   = 4;
  localparam int PRM_AW  = 2;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n = 1'b0, rrst_n = 1'b0;
  logic wr_valid = 1'b0, wr_sof = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic rd_en = 1'b0, rd_release = 1'b0, rd_ovr_clr = 1'b0;
  logic [BANK_AW-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic rd_valid, rd_bank, rd_irq, rd_overrun;
  logic prm_we = 1'b0;
  logic [PRM_AW-1:0] prm_addr = '0;
  logic [DATA_W-1:0] prm_wdata = '0;
  logic [PRM_N*DATA_W-1:0] prm_words;

  int checks = 0, errors = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #2.5 wclk = ~wclk;
  always #4   rclk = ~rclk;

  pp_handoff_buf #(.DATA_W(DATA_W), .BANK_AW(BANK_AW), .PRM_N(PRM_N)) dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_sof(wr_sof),
    .wr_data(wr_data), .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_bank(rd_bank), .rd_irq(rd_irq), .rd_release(rd_release),
    .rd_overrun(rd_overrun), .rd_ovr_clr(rd_ovr_clr), .prm_we(prm_we),
    .prm_addr(prm_addr), .prm_wdata(prm_wdata), .prm_words(prm_words)
  );

  always @(negedge rclk) if (rrst_n && rd_irq) irq_cnt++;

  function automatic logic [DATA_W-1:0] pat(input logic [7:0] seed, input int i);
    return {seed, 8'(i * 7 + 3), 16'(i)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic send_symbol(input logic [7:0] seed, input int n, input bit with_sof);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_valid = 1'b1;
      wr_sof   = with_sof && (i == 0);
      wr_data  = pat(seed, i);
    end
    @(negedge wclk);
    wr_valid = 1'b0;
    wr_sof   = 1'b0;
  endtask

  task automatic release_bank();
    @(negedge rclk) rd_release = 1'b1;
    @(negedge rclk) rd_release = 1'b0;
  endtask

  task automatic check_bank(input logic [7:0] seed, input string req);
    int bad = 0;
    logic [DATA_W-1:0] first_act = '0, first_exp = '0;
    for (int i = 0; i < WORDS; i++) begin
      @(negedge rclk);
      rd_en = 1'b1;
      rd_addr = BANK_AW'(i);
      @(negedge rclk);
      rd_en = 1'b0;
      if (rd_data !== pat(seed, i)) begin
        if (bad == 0) begin first_act = rd_data; first_exp = pat(seed, i); end
        bad++;
      end
    end
    chk(bad == 0, req, 64'(first_act), 64'(first_exp));
  endtask

  task automatic t_reset();
    chk(rd_valid == 1'b0, "R1 rd_valid", 64'(rd_valid), 0);
    chk(rd_irq == 1'b0, "R1 rd_irq", 64'(rd_irq), 0);
    chk(rd_overrun == 1'b0, "R1 rd_overrun", 64'(rd_overrun), 0);
    chk(prm_words == '0, "R1 params", 64'(prm_words), 0);
  endtask

  task automatic t_first_fill();
    int c0 = irq_cnt;
    send_symbol(8'hA1, WORDS, 1'b1);
    settle(20);
    chk(irq_cnt == c0 + 1, "R2 single irq pulse", 64'(irq_cnt - c0), 1);
    chk(rd_valid == 1'b1, "R2 rd_valid", 64'(rd_valid), 1);
    chk(rd_bank == 1'b0, "R3 first bank is 0", 64'(rd_bank), 0);
    check_bank(8'hA1, "R4 bank0 data");
  endtask

  task automatic t_second_fill();
    int c0 = irq_cnt;
    send_symbol(8'hB2, WORDS, 1'b1);
    settle(20);
    chk(irq_cnt == c0 + 1, "R3 second bank irq", 64'(irq_cnt - c0), 1);
    chk(rd_bank == 1'b0, "R3 head stays on bank0", 64'(rd_bank), 0);
    check_bank(8'hA1, "R3 bank0 untouched");
    release_bank();
    settle(2);
    chk(rd_bank == 1'b1 && rd_valid == 1'b1, "R5 release moves to bank1",
        64'({rd_bank, rd_valid}), 64'h3);
    check_bank(8'hB2, "R3 bank1 data");
    settle(20);
  endtask

  task automatic t_overrun();
    int c0 = irq_cnt;
    send_symbol(8'hC3, WORDS, 1'b1);
    settle(20);
    chk(irq_cnt == c0 + 1, "R3 refill bank0 irq", 64'(irq_cnt - c0), 1);
    send_symbol(8'hD4, WORDS, 1'b1);
    settle(20);
    chk(irq_cnt == c0 + 1, "R6 dropped symbol gives no irq", 64'(irq_cnt - c0), 1);
    chk(rd_overrun == 1'b1, "R7 overrun set", 64'(rd_overrun), 1);
    check_bank(8'hB2, "R6 bank1 kept");
    release_bank();
    settle(2);
    chk(rd_bank == 1'b0, "R3 order bank0 next", 64'(rd_bank), 0);
    check_bank(8'hC3, "R6 bank0 not overwritten by drop");
    release_bank();
    settle(2);
    chk(rd_valid == 1'b0, "R5 nothing held", 64'(rd_valid), 0);
    settle(10);
    chk(rd_overrun == 1'b1, "R7 overrun sticky", 64'(rd_overrun), 1);
    @(negedge rclk) rd_ovr_clr = 1'b1;
    @(negedge rclk) rd_ovr_clr = 1'b0;
    settle(20);
    chk(rd_overrun == 1'b0, "R7 overrun cleared", 64'(rd_overrun), 0);
  endtask

  task automatic t_restart();
    int c0 = irq_cnt;
    send_symbol(8'hE5, 100, 1'b1);
    send_symbol(8'hF6, WORDS, 1'b1);
    settle(20);
    chk(irq_cnt == c0 + 1, "R8 one irq after restart", 64'(irq_cnt - c0), 1);
    chk(rd_bank == 1'b1, "R8 restart keeps bank1", 64'(rd_bank), 1);
    check_bank(8'hF6, "R8 restarted data");
    release_bank();
    settle(20);
  endtask

  task automatic t_stray_release();
    int c0 = irq_cnt;
    release_bank();
    settle(2);
    chk(rd_valid == 1'b0 && rd_bank == 1'b0, "R5 stray release ignored",
        64'({rd_bank, rd_valid}), 0);
    send_symbol(8'h17, WORDS, 1'b1);
    settle(20);
    chk(rd_valid == 1'b1 && rd_bank == 1'b0, "R5 next fill presented on bank0",
        64'({rd_bank, rd_valid}), 1);
    chk(irq_cnt == c0 + 1, "R2 irq after fill", 64'(irq_cnt - c0), 1);
    check_bank(8'h17, "R4 bank0 data after stray release");
    release_bank();
    settle(20);
  endtask

  task automatic t_no_sof();
    int c0 = irq_cnt;
    send_symbol(8'h28, WORDS + 4, 1'b0);
    settle(20);
    chk(irq_cnt == c0, "R9 no irq without sof", 64'(irq_cnt - c0), 0);
    chk(rd_valid == 1'b0, "R9 no bank without sof", 64'(rd_valid), 0);
    send_symbol(8'h39, WORDS, 1'b1);
    settle(20);
    chk(rd_bank == 1'b1 && rd_valid == 1'b1, "R9 next fill still bank1",
        64'({rd_bank, rd_valid}), 64'h3);
    check_bank(8'h39, "R9 data unaffected by stray words");
  endtask

  task automatic t_params();
    for (int i = 0; i < PRM_N; i++) begin
      @(negedge rclk);
      prm_we = 1'b1;
      prm_addr = PRM_AW'(i);
      prm_wdata = 32'h5A000000 | 32'(i * 17);
    end
    @(negedge rclk) prm_we = 1'b0;
    for (int i = 0; i < PRM_N; i++) begin
      logic [31:0] got = prm_words[i*32 +: 32];
      chk(got == (32'h5A000000 | 32'(i * 17)), "R10 parameter word", 64'(got),
          64'(32'h5A000000 | 32'(i * 17)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge rclk);
    wrst_n = 1'b1;
    rrst_n = 1'b1;
    settle(2);
    t_reset();
    t_first_fill();
    t_second_fill();
    t_overrun();
    t_restart();
    t_stray_release();
    t_no_sof();
    t_params();
    finish_run();
  end
endmodule